// File: doc/BRIEF.md
# Circuit-Switched Memory Gateway Controller

This controller sits at one DRAM access point of a circuit-switched on-chip network. It takes one read or write request at a time from a processor and walks the whole transaction through a fixed sequence. It configures the photonic switch, acknowledges the end-to-end path to the requester and sends a row/column command packet to the DIMM. It then opens a data window and finally tears the circuit down. Contention between processors is resolved when the path is set up, so the controller has no arbiter. While a transaction is in flight it holds further requests off with a not-ready signal.

The two directions use different orders. A read turns on the command-modulator and DIMM-to-network switch paths together. Once the switch reports done, it acknowledges the path, sends the command and keeps the circuit for a length it computes in advance. That length is the command latency, plus row-to-column delay, plus CAS latency, plus the burst in beats. No end-of-data signal is needed. A write counts as a path setup from the requester. It turns on the modulator path and sends the command, then turns on the network-to-DIMM path, acknowledges and opens the data window. The window stays open until the requester releases the circuit. Each wait for the switch is bounded by a programmable timeout. When the timeout runs out, the transaction is aborted and every switch enable is released.

Top module: `mgw_ctrl`

## Requirements
- R1: For a read, `sw_mod_en` and `sw_ret_en` rise together in the cycle after the request is accepted. `path_ack` is high for exactly one cycle, and only in the cycle after `sw_done` was sampled high during that wait.
- R2: `cmd_valid` rises in the cycle after a read's acknowledge, or after a write's first `sw_done`. It stays high with `cmd_data` unchanged until `cmd_ready` is sampled. The packet is {write flag (MSB), bank, row, column, burst (LSBs)}.
- R3: After a read command handshake, `rd_window` is high for exactly CMD_LAT+T_RCD+T_CL+burst+1 cycles. Then comes one teardown cycle with all switch enables low, and then idle.
- R4: For a write, the order is: `sw_mod_en` alone, then command, then `sw_net_en` (waiting for `sw_done`), then a one-cycle `path_ack`, then `wr_window`. `sw_ret_en` stays low throughout a write.
- R5: `wr_window` stays high until `rq_release` is sampled. It is followed by one teardown cycle with all switch enables low, and then idle.
- R6: The burst field counts beats minus one. The largest value (2^BURST_W-1, 4096 beats) is timed in full.
- R7: `req_ready` is high only when idle. A request offered while busy is ignored.
- R8: In a switch wait, if `sw_done` has not been sampled by the edge at which timeout_cfg+1 cycles have passed, `abort` is high for one cycle with all switch enables low, and then the controller is idle. A `sw_done` on that last edge still succeeds.
- R9: During and right after reset, every output is low except `req_ready`.
- R10: `sw_done`, `cmd_ready` and `rq_release` have no effect outside the state that waits for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank index |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_burst | input | BURST_W | Burst length in beats minus one |
| timeout_cfg | input | TO_W | Switch wait limit |
| sw_mod_en | output | 1 | Connect command modulators to DIMM |
| sw_ret_en | output | 1 | Connect DIMM to network (read return) |
| sw_net_en | output | 1 | Connect network to DIMM (write data) |
| sw_done | input | 1 | Switch reports requested configuration set |
| path_ack | output | 1 | Path acknowledge to requester |
| cmd_valid | output | 1 | Command packet valid |
| cmd_ready | input | 1 | Command packet taken |
| cmd_data | output | PKT_W | Command packet |
| rd_window | output | 1 | Read data streaming on circuit |
| wr_window | output | 1 | Write data accepted on circuit |
| rq_release | input | 1 | Requester releases write circuit |
| abort | output | 1 | Transaction aborted on timeout |

## Verification
Every output is decoded from registered state, so each result lands one clock after the edge that samples its cause. Examples: switch enables one cycle after acceptance, `path_ack` one cycle after `sw_done`, the read window starting one cycle after the command handshake, and teardown right after the last window cycle. The bench's reference model steps on the same edge as the design. All outputs are compared at the falling edge that follows. Stimulus is driven at that falling edge from the model's state, so its timing never depends on the design. Long bursts, zero bursts, a timeout hit exactly on the limit edge, and stray handshakes are each run as their own scenario.

// File: rtl/mgw_pkg.sv
package mgw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_SWM  = 4'd1,   // modulator (and read return) path being set
    ST_ACKR = 4'd2,   // read path acknowledge
    ST_CMD  = 4'd3,   // command packet offered
    ST_RDAT = 4'd4,   // read data on circuit, timed
    ST_SWN  = 4'd5,   // write data path being set
    ST_ACKW = 4'd6,   // write path acknowledge
    ST_WDAT = 4'd7,   // write data on circuit
    ST_TEAR = 4'd8,   // circuit released
    ST_ABRT = 4'd9    // switch wait expired
  } gw_state_e;
endpackage

// File: rtl/mgw_req_hold.sv
module mgw_req_hold #(
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 14,
  parameter int COL_W   = 10,
  parameter int BURST_W = 12,
  localparam int PKT_W  = 1 + BANK_W + ROW_W + COL_W + BURST_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic               in_write,
  input  logic [BANK_W-1:0]  in_bank,
  input  logic [ROW_W-1:0]   in_row,
  input  logic [COL_W-1:0]   in_col,
  input  logic [BURST_W-1:0] in_burst,
  output logic               is_write_q,
  output logic [BURST_W-1:0] burst_q,
  output logic [PKT_W-1:0]   pkt_q
);
  logic [PKT_W-1:0] pkt_d;

  always_comb begin
    pkt_d = {in_write, in_bank, in_row, in_col, in_burst};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_q <= '0;
    end else if (capture) begin
      pkt_q <= pkt_d;
    end
  end

  assign is_write_q = pkt_q[PKT_W-1];
  assign burst_q    = pkt_q[BURST_W-1:0];
endmodule

// File: rtl/mgw_tmo.sv
module mgw_tmo #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            hit
);
  logic [TO_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)           cnt_d = '0;
    else if (cnt_q != limit) cnt_d = cnt_q + TO_W'(1);
    else                cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = run && (cnt_q == limit);
endmodule

// File: rtl/mgw_rd_timer.sv
module mgw_rd_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  always_comb begin
    en    = load || (run && (cnt_q != '0));
    cnt_d = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/mgw_seq.sv
module mgw_seq
  import mgw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      is_write,
  input  logic      sw_done,
  input  logic      tmo_hit,
  input  logic      cmd_ready,
  input  logic      rd_zero,
  input  logic      rq_release,
  output gw_state_e state
);
  gw_state_e st_d;

  always_comb begin
    st_d = state;
    unique case (state)
      ST_IDLE: if (req_valid) st_d = ST_SWM;
      ST_SWM: begin
        if (sw_done)      st_d = is_write ? ST_CMD : ST_ACKR;
        else if (tmo_hit) st_d = ST_ABRT;
      end
      ST_ACKR: st_d = ST_CMD;
      ST_CMD:  if (cmd_ready) st_d = is_write ? ST_SWN : ST_RDAT;
      ST_RDAT: if (rd_zero) st_d = ST_TEAR;
      ST_SWN: begin
        if (sw_done)      st_d = ST_ACKW;
        else if (tmo_hit) st_d = ST_ABRT;
      end
      ST_ACKW: st_d = ST_WDAT;
      ST_WDAT: if (rq_release) st_d = ST_TEAR;
      ST_TEAR: st_d = ST_IDLE;
      ST_ABRT: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= st_d;
  end
endmodule

// File: rtl/mgw_ctrl.sv
module mgw_ctrl
  import mgw_pkg::*;
#(
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 14,
  parameter int COL_W   = 10,
  parameter int BURST_W = 12,
  parameter int TO_W    = 8,
  parameter int CMD_LAT = 2,
  parameter int T_RCD   = 5,
  parameter int T_CL    = 5,
  localparam int PKT_W  = 1 + BANK_W + ROW_W + COL_W + BURST_W,
  localparam int FIXED_LAT = CMD_LAT + T_RCD + T_CL,
  localparam int CNT_W  = $clog2(FIXED_LAT + (1 << BURST_W)) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_is_write,
  input  logic [BANK_W-1:0]  req_bank,
  input  logic [ROW_W-1:0]   req_row,
  input  logic [COL_W-1:0]   req_col,
  input  logic [BURST_W-1:0] req_burst,
  input  logic [TO_W-1:0]    timeout_cfg,
  output logic               sw_mod_en,
  output logic               sw_ret_en,
  output logic               sw_net_en,
  input  logic               sw_done,
  output logic               path_ack,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [PKT_W-1:0]   cmd_data,
  output logic               rd_window,
  output logic               wr_window,
  input  logic               rq_release,
  output logic               abort
);
  gw_state_e          state;
  logic               is_write_q;
  logic [BURST_W-1:0] burst_q;
  logic               capture;
  logic               tmo_run, tmo_hit;
  logic               rd_load, rd_zero;
  logic [CNT_W-1:0]   rd_len;

  assign capture = (state == ST_IDLE) && req_valid;

  mgw_req_hold #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BURST_W(BURST_W)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .in_write(req_is_write), .in_bank(req_bank), .in_row(req_row),
    .in_col(req_col), .in_burst(req_burst),
    .is_write_q(is_write_q), .burst_q(burst_q), .pkt_q(cmd_data)
  );

  assign tmo_run = (state == ST_SWM) || (state == ST_SWN);

  mgw_tmo #(.TO_W(TO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(tmo_run), .limit(timeout_cfg), .hit(tmo_hit)
  );

  // window length minus one, fixed at the command handshake
  assign rd_load = (state == ST_CMD) && cmd_ready && !is_write_q;
  assign rd_len  = CNT_W'(FIXED_LAT) + CNT_W'(burst_q);

  mgw_rd_timer #(.CNT_W(CNT_W)) u_rd_timer (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .load_val(rd_len),
    .run(state == ST_RDAT), .zero(rd_zero)
  );

  mgw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_write(is_write_q),
    .sw_done(sw_done), .tmo_hit(tmo_hit), .cmd_ready(cmd_ready),
    .rd_zero(rd_zero), .rq_release(rq_release), .state(state)
  );

  logic rd_phase, wr_phase;

  always_comb begin
    rd_phase  = (state == ST_SWM) || (state == ST_ACKR) ||
                (state == ST_CMD) || (state == ST_RDAT);
    wr_phase  = (state == ST_SWN) || (state == ST_ACKW) || (state == ST_WDAT);
    req_ready = (state == ST_IDLE);
    sw_mod_en = rd_phase || wr_phase;
    sw_ret_en = rd_phase && !is_write_q;
    sw_net_en = wr_phase && is_write_q;
    path_ack  = (state == ST_ACKR) || (state == ST_ACKW);
    cmd_valid = (state == ST_CMD);
    rd_window = (state == ST_RDAT);
    wr_window = (state == ST_WDAT);
    abort     = (state == ST_ABRT);
  end
endmodule

// File: rtl/mgw_ctrl_chk.sv
module mgw_ctrl_chk #(
  parameter int PKT_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             sw_mod_en,
  input logic             sw_ret_en,
  input logic             sw_net_en,
  input logic             sw_done,
  input logic             path_ack,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [PKT_W-1:0] cmd_data,
  input logic             rd_window,
  input logic             wr_window,
  input logic             rq_release,
  input logic             abort
);
  // R1
  rd_ack_after_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    path_ack && sw_ret_en |-> $past(sw_done) && $past(sw_ret_en));
  // R1
  rd_paths_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_ret_en) |-> sw_mod_en && $rose(sw_mod_en));
  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));
  // R3
  rd_teardown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_window) |-> !sw_mod_en && !sw_ret_en && !sw_net_en);
  // R4
  wr_net_needs_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_net_en |-> sw_mod_en && !sw_ret_en);
  // R4
  wr_ack_after_net_chk: assert property (@(posedge clk) disable iff (!rst_n)
    path_ack && sw_net_en |-> $past(sw_done) && $past(sw_net_en));
  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_window && !rq_release |=> wr_window);
  // R7
  one_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R8
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !sw_mod_en && !sw_ret_en && !sw_net_en);
  // R8
  abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> req_ready && !abort);
  // R1
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({path_ack, cmd_valid, rd_window, wr_window, abort, req_ready}));
endmodule

bind mgw_ctrl mgw_ctrl_chk #(.PKT_W(PKT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .sw_mod_en(sw_mod_en), .sw_ret_en(sw_ret_en), .sw_net_en(sw_net_en),
  .sw_done(sw_done), .path_ack(path_ack), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_data(cmd_data), .rd_window(rd_window),
  .wr_window(wr_window), .rq_release(rq_release), .abort(abort)
);

// File: tb/mgw_ctrl_bench.sv
module mgw_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BANK_W = 3, ROW_W = 14, COL_W = 10, BURST_W = 12, TO_W = 8;
  localparam int CMD_LAT = 2, T_RCD = 5, T_CL = 5;
  localparam int PKT_W = 1 + BANK_W + ROW_W + COL_W + BURST_W;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_is_write;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic [BURST_W-1:0] req_burst;
  logic [TO_W-1:0] timeout_cfg;
  logic sw_mod_en, sw_ret_en, sw_net_en, sw_done, path_ack;
  logic cmd_valid, cmd_ready, rd_window, wr_window, rq_release, abort;
  logic [PKT_W-1:0] cmd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgw_ctrl u_mgw_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_write(req_is_write), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_burst(req_burst), .timeout_cfg(timeout_cfg),
    .sw_mod_en(sw_mod_en), .sw_ret_en(sw_ret_en), .sw_net_en(sw_net_en),
    .sw_done(sw_done), .path_ack(path_ack), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .rd_window(rd_window),
    .wr_window(wr_window), .rq_release(rq_release), .abort(abort)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  string scen = "R9";

  // reference model: phase names as integers
  localparam int P_IDLE = 0, P_SETUP = 1, P_RACK = 2, P_CMD = 3, P_READ = 4;
  localparam int P_WNET = 5, P_WACK = 6, P_WRITE = 7, P_DOWN = 8, P_ABORT = 9;
  int m_ph, m_wait, m_cw, m_rw, m_beats;
  bit m_wr;
  logic [PKT_W-1:0] m_pkt;
  int m_len;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= P_IDLE; m_wait <= 0; m_cw <= 0; m_rw <= 0; m_beats <= 0;
      m_wr <= 0; m_pkt <= '0; m_len <= 0;
    end else begin
      case (m_ph)
        P_IDLE: if (req_valid) begin
          m_ph <= P_SETUP; m_wait <= 0; m_wr <= req_is_write;
          m_pkt <= {req_is_write, req_bank, req_row, req_col, req_burst};
          m_len <= CMD_LAT + T_RCD + T_CL + int'(req_burst) + 1;
        end
        P_SETUP: begin
          if (sw_done) begin m_ph <= m_wr ? P_CMD : P_RACK; m_cw <= 0; end
          else if (m_wait == int'(timeout_cfg)) m_ph <= P_ABORT;
          else m_wait <= m_wait + 1;
        end
        P_RACK: begin m_ph <= P_CMD; m_cw <= 0; end
        P_CMD: begin
          if (cmd_ready) begin
            if (m_wr) begin m_ph <= P_WNET; m_wait <= 0; end
            else begin m_ph <= P_READ; m_beats <= 1; end
          end else m_cw <= m_cw + 1;
        end
        P_READ: if (m_beats >= m_len) m_ph <= P_DOWN; else m_beats <= m_beats + 1;
        P_WNET: begin
          if (sw_done) m_ph <= P_WACK;
          else if (m_wait == int'(timeout_cfg)) m_ph <= P_ABORT;
          else m_wait <= m_wait + 1;
        end
        P_WACK: begin m_ph <= P_WRITE; m_rw <= 0; end
        P_WRITE: if (rq_release) m_ph <= P_DOWN; else m_rw <= m_rw + 1;
        default: m_ph <= P_IDLE;
      endcase
    end
  end

  task automatic chk(input bit act, input bit exp, input string req, input string name);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] %s act=%0b exp=%0b t=%0t", req, scen, name, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit setup_rd, setup_wr;
    string dr;
    dr = m_wr ? "R4" : "R1";
    setup_rd = !m_wr && (m_ph inside {P_SETUP, P_RACK, P_CMD, P_READ});
    setup_wr = m_wr && (m_ph inside {P_SETUP, P_CMD, P_WNET, P_WACK, P_WRITE});
    chk(req_ready, m_ph == P_IDLE, "R7", "req_ready");
    chk(sw_mod_en, setup_rd || setup_wr, dr, "sw_mod_en");
    chk(sw_ret_en, setup_rd, "R1", "sw_ret_en");
    chk(sw_net_en, m_wr && (m_ph inside {P_WNET, P_WACK, P_WRITE}), "R4", "sw_net_en");
    chk(path_ack, m_ph == P_RACK || m_ph == P_WACK, dr, "path_ack");
    chk(cmd_valid, m_ph == P_CMD, "R2", "cmd_valid");
    chk(rd_window, m_ph == P_READ, "R3", "rd_window");
    chk(wr_window, m_ph == P_WRITE, "R5", "wr_window");
    chk(abort, m_ph == P_ABORT, "R8", "abort");
    if (m_ph == P_CMD) begin
      tests++;
      if (cmd_data !== m_pkt) begin
        fails++;
        $display("FAIL R2 [%s] cmd_data act=%h exp=%h", scen, cmd_data, m_pkt);
      end
    end
  endtask

  // knobs
  int k_sw = 0, k_cmd = 0, k_rel = 0;
  bit want_req = 0, junk = 0, stray = 0;

  task automatic step();
    @(negedge clk);
    compare();
    if (m_ph != P_IDLE) want_req = 0;
    req_valid  = want_req || (junk && m_ph != P_IDLE);
    if (junk && m_ph != P_IDLE) begin
      req_is_write = ~req_is_write; req_bank = req_bank + 1; req_burst = 12'hFFF;
    end
    sw_done    = ((m_ph == P_SETUP || m_ph == P_WNET) && m_wait == k_sw) ||
                 (stray && !(m_ph inside {P_SETUP, P_WNET}) && $urandom_range(0, 1) == 1);
    cmd_ready  = (m_ph == P_CMD && m_cw == k_cmd) ||
                 (stray && m_ph != P_CMD && $urandom_range(0, 1) == 1);
    rq_release = (m_ph == P_WRITE && m_rw == k_rel) ||
                 (stray && m_ph != P_WRITE && $urandom_range(0, 1) == 1);
  endtask

  task automatic txn(input bit wr, input int burst, input int sw, input int cw, input int rl);
    k_sw = sw; k_cmd = cw; k_rel = rl;
    req_is_write = wr; req_bank = 3'(burst + 5); req_row = 14'(burst * 77 + 1234);
    req_col = 10'(burst * 3 + 17); req_burst = 12'(burst);
    want_req = 1;
    step();
    for (int i = 0; i < 6000 && (want_req || m_ph != P_IDLE); i++) step();
    junk = 0;
    for (int i = 0; i < 3; i++) step();
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_is_write = 0; req_bank = '0; req_row = '0;
    req_col = '0; req_burst = '0; timeout_cfg = 8'd20;
    sw_done = 0; cmd_ready = 0; rq_release = 0;
    repeat (3) @(negedge clk);
    compare();                      // R9 in reset
    rst_n = 1;
    step(); step();                 // R9 after release
    scen = "R1"; txn(0, 3, 2, 1, 0);
    scen = "R2"; txn(0, 7, 0, 4, 0);
    scen = "R3"; txn(0, 0, 0, 0, 0);
    scen = "R4"; txn(1, 5, 3, 2, 4);
    scen = "R5"; txn(1, 1, 0, 0, 0);
    scen = "R5"; txn(1, 9, 1, 0, 12);
    scen = "R7"; junk = 1; txn(0, 4, 1, 1, 0);
    scen = "R7"; junk = 1; txn(1, 2, 1, 1, 3);
    timeout_cfg = 8'd3;
    scen = "R8"; txn(0, 2, 50, 0, 0);          // read setup expires
    scen = "R8"; txn(1, 2, 3, 0, 1);           // done on the limit edge
    k_sw = 0; scen = "R8"; txn(1, 2, 0, 0, 0); // normal write under short limit
    // write whose second switch wait expires: first wait at 0, second never
    scen = "R8"; k_cmd = 0; k_rel = 0;
    req_is_write = 1; req_burst = 12'd1; want_req = 1; k_sw = 0;
    for (int i = 0; i < 200 && (want_req || m_ph != P_IDLE); i++) begin
      k_sw = (m_ph == P_WNET || m_ph == P_CMD) ? 99 : 0;
      step();
    end
    for (int i = 0; i < 3; i++) step();
    timeout_cfg = 8'd20;
    scen = "R10"; stray = 1;
    for (int i = 0; i < 10; i++) step();
    txn(0, 6, 2, 2, 0);
    txn(1, 3, 1, 1, 2);
    stray = 0;
    scen = "R6"; txn(0, 4095, 0, 0, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule